// File: doc/BRIEF.md
# Reset Sequencer with Boot Mode Capture

This block is the reset controller of a small microcontroller-style system. It gathers reset requests from a power-on source, from the bidirectional reset pin, from a parameterised set of internal sources such as a watchdog or an illegal-opcode detector, and from a debug-forced request. It drives the system reset and an open-drain pull-down enable for the reset pin. It records the cause of the last reset as a one-hot status word that software can read.

Any reset that is not a power-on reset drives the reset pin low for a fixed number of bus cycles, 66 by default. The controller then waits until the pin reads high again before it lets the system run. This way, an external agent that holds the pin low keeps the whole system in reset.

When the reset ends after a power-on or debug-forced reset, the controller samples a mode-select input. A low level selects background debug mode and a high level selects normal run mode. Every reset sets the debug-pin enable, and while that enable is set the pin's pull-up is requested. Software clears the enable to hand the pin to its general-purpose function.

Top module: `rst_sequencer`

## Requirements
- R1: A reset from an internal source, the debug-force request or the pin drives `rst_pin_drive` high for exactly PULSE_LEN consecutive cycles (66 by default), starting the cycle after the request is sampled, with `sys_rst` high throughout.
- R2: While `rst` (power-on) is high, `sys_rst` is high and `rst_pin_drive` stays low; after `rst` falls, `sys_rst` is released without any pin pulse.
- R3: `reset_status` always has exactly one bit set. Bit 0 is power-on, bit 1 is the pin, bit 2 is debug-force and bit 3+i is internal source i.
- R4: The reset pin read low through a two-flop synchronizer, while the system runs, starts a reset recorded as the pin cause (bit 1).
- R5: Causes present in the same cycle are recorded by priority: debug-force first, then internal sources with the lower index first, then the pin. Power-on overrides all and clears every other bit.
- R6: When the reset ends, the synchronized `mode_sel_in` sets `bkgd_mode`, only after a power-on or debug-forced reset: low gives `bkgd_mode`=1 and high gives 0. Any other reset leaves `bkgd_mode`=0.
- R7: Every reset sets `dbg_pin_en` to 1. A `dbg_en_clr` pulse while `sys_rst` is low clears it, and the pulse is ignored while `sys_rst` is high.
- R8: `dbg_pullup_en` is high exactly when `dbg_pin_en` is high.
- R9: Requests that arrive while a reset is in progress are absorbed: `reset_status` does not change and no second reset follows the release.
- R10: After the pulse ends, `sys_rst` stays high until the synchronized pin reads high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Power-on reset, synchronous, active high |
| rst_pin_in | input | 1 | Level read back from the reset pin (low = asserted) |
| int_req | input | NUM_INT | Internal reset requests, one per source, active high |
| dbg_force_req | input | 1 | Debug-forced reset request, active high |
| mode_sel_in | input | 1 | Mode-select pin level |
| dbg_en_clr | input | 1 | Software pulse clearing the debug-pin enable |
| sys_rst | output | 1 | System reset, active high |
| rst_pin_drive | output | 1 | Open-drain pull-down enable for the reset pin |
| reset_status | output | 3+NUM_INT | One-hot cause of the last reset |
| bkgd_mode | output | 1 | 1 = background debug mode selected |
| dbg_pin_en | output | 1 | Debug-pin function enable |
| dbg_pullup_en | output | 1 | Pull-up request for the debug pin |

## Verification
Two things can land in one cycle. Several reset causes can arrive at the same edge, and a new request can arrive during a reset that is already running. The bench provokes the first by lining up the synchronized pin-low edge with internal and debug-force pulses in one cycle, and judges it by the single status bit that wins. It provokes the second by firing requests in the middle of the driven pulse, and judges it by an unchanged status and the absence of any second reset after the release.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

    // status bit positions; internal sources follow from ST_INT0 upward
    localparam int ST_POR  = 0;
    localparam int ST_PIN  = 1;
    localparam int ST_DBG  = 2;
    localparam int ST_INT0 = 3;

    typedef enum logic [1:0] {
        SEQ_RUN      = 2'd0,
        SEQ_DRIVE    = 2'd1,
        SEQ_WAIT_PIN = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic valid;        // some cause present this cycle
        logic sample_mode;  // winning cause samples the mode pin on release
    } cause_info_t;

    function automatic int status_width(input int n_int);
        return ST_INT0 + n_int;
    endfunction

endpackage

// File: rtl/rst_seq_sync.sv
module rst_seq_sync #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage1;

    // not reset: keeps tracking the pins while power-on reset is held
    always_ff @(posedge clk) begin
        stage1 <= d;
        q      <= stage1;
    end
endmodule

// File: rtl/rst_seq_cause.sv
module rst_seq_cause
    import rst_seq_pkg::*;
#(
    parameter int NUM_INT = 2,
    localparam int SW = status_width(NUM_INT)
) (
    input  logic               dbg_req,
    input  logic [NUM_INT-1:0] int_req,
    input  logic               pin_req,
    output cause_info_t        info,
    output logic [SW-1:0]      onehot
);
    logic found;

    always_comb begin
        onehot           = '0;
        info.valid       = 1'b0;
        info.sample_mode = 1'b0;
        found            = 1'b0;
        if (dbg_req) begin
            onehot[ST_DBG]   = 1'b1;
            info.valid       = 1'b1;
            info.sample_mode = 1'b1;
        end else begin
            for (int i = 0; i < NUM_INT; i++) begin
                if (int_req[i] && !found) begin
                    onehot[ST_INT0+i] = 1'b1;
                    found             = 1'b1;
                end
            end
            if (found) begin
                info.valid = 1'b1;
            end else if (pin_req) begin
                onehot[ST_PIN] = 1'b1;
                info.valid     = 1'b1;
            end
        end
    end
endmodule

// File: rtl/rst_seq_pulse_timer.sv
module rst_seq_pulse_timer #(
    parameter int LEN = 66,
    localparam int CW = $clog2(LEN + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic done
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) cnt <= '0;
        else             cnt <= cnt + 1'b1;
    end

    assign done = run && (cnt == CW'(LEN - 1));
endmodule

// File: rtl/rst_sequencer.sv
module rst_sequencer
    import rst_seq_pkg::*;
#(
    parameter int NUM_INT   = 2,
    parameter int PULSE_LEN = 66
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       rst_pin_in,
    input  logic [NUM_INT-1:0]         int_req,
    input  logic                       dbg_force_req,
    input  logic                       mode_sel_in,
    input  logic                       dbg_en_clr,
    output logic                       sys_rst,
    output logic                       rst_pin_drive,
    output logic [ST_INT0+NUM_INT-1:0] reset_status,
    output logic                       bkgd_mode,
    output logic                       dbg_pin_en,
    output logic                       dbg_pullup_en
);
    localparam int SW = status_width(NUM_INT);

    seq_state_e    state;
    logic [1:0]    sync_q;
    logic          pin_hi, mode_hi, pulse_done, sample_flag;
    cause_info_t   info;
    logic [SW-1:0] cause_onehot, status_q;

    rst_seq_sync #(.WIDTH(2)) u_sync (
        .clk (clk),
        .d   ({mode_sel_in, rst_pin_in}),
        .q   (sync_q)
    );
    assign pin_hi  = sync_q[0];
    assign mode_hi = sync_q[1];

    rst_seq_cause #(.NUM_INT(NUM_INT)) u_cause (
        .dbg_req (dbg_force_req),
        .int_req (int_req),
        .pin_req (!pin_hi),
        .info    (info),
        .onehot  (cause_onehot)
    );

    rst_seq_pulse_timer #(.LEN(PULSE_LEN)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (state == SEQ_DRIVE),
        .done (pulse_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state           <= SEQ_WAIT_PIN;
            status_q        <= '0;
            status_q[ST_POR] <= 1'b1;
            sample_flag     <= 1'b1;
            dbg_pin_en      <= 1'b1;
            bkgd_mode       <= 1'b0;
        end else begin
            case (state)
                SEQ_RUN: begin
                    if (info.valid) begin
                        state       <= SEQ_DRIVE;
                        status_q    <= cause_onehot;
                        sample_flag <= info.sample_mode;
                        dbg_pin_en  <= 1'b1;
                    end else if (dbg_en_clr) begin
                        dbg_pin_en  <= 1'b0;
                    end
                end
                SEQ_DRIVE: begin
                    if (pulse_done) state <= SEQ_WAIT_PIN;
                end
                SEQ_WAIT_PIN: begin
                    if (pin_hi) begin
                        state     <= SEQ_RUN;
                        bkgd_mode <= sample_flag ? !mode_hi : 1'b0;
                    end
                end
                default: state <= SEQ_WAIT_PIN;
            endcase
        end
    end

    assign sys_rst       = rst || (state != SEQ_RUN);
    assign rst_pin_drive = !rst && (state == SEQ_DRIVE);
    assign reset_status  = status_q;
    assign dbg_pullup_en = dbg_pin_en;
endmodule

// File: rtl/rst_sequencer_chk.sv
module rst_sequencer_chk #(
    parameter int SW = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          sys_rst,
    input logic          rst_pin_drive,
    input logic [SW-1:0] reset_status,
    input logic          bkgd_mode,
    input logic          dbg_pin_en
);
    // R3
    status_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot(reset_status));

    // R1
    drive_in_reset_chk: assert property (@(posedge clk) disable iff (rst)
        rst_pin_drive |-> sys_rst);

    // R10
    hold_after_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst_pin_drive) |-> sys_rst);

    // R7
    dbg_en_on_release_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sys_rst) |-> dbg_pin_en);

    // R9
    status_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (sys_rst && $past(sys_rst)) |-> $stable(reset_status));

    // R6
    mode_stable_run_chk: assert property (@(posedge clk) disable iff (rst)
        (!sys_rst && $past(!sys_rst)) |-> $stable(bkgd_mode));
endmodule

bind rst_sequencer rst_sequencer_chk #(.SW(rst_seq_pkg::ST_INT0 + NUM_INT)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .sys_rst       (sys_rst),
    .rst_pin_drive (rst_pin_drive),
    .reset_status  (reset_status),
    .bkgd_mode     (bkgd_mode),
    .dbg_pin_en    (dbg_pin_en)
);

// File: tb/rst_sequencer_bench.sv
module rst_sequencer_bench;
    localparam int NUM_INT = 2;
    localparam int PLEN    = 66;
    localparam int SW      = 3 + NUM_INT;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ext_low = 1'b0;
    logic [NUM_INT-1:0] int_req = '0;
    logic dbg_force_req = 1'b0;
    logic mode_sel_in = 1'b1;
    logic dbg_en_clr = 1'b0;
    logic rst_pin_in, sys_rst, rst_pin_drive, bkgd_mode, dbg_pin_en, dbg_pullup_en;
    logic [SW-1:0] reset_status;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    // open-drain pin: low if the block or an outside agent pulls it
    assign rst_pin_in = !(rst_pin_drive || ext_low);

    rst_sequencer #(.NUM_INT(NUM_INT), .PULSE_LEN(PLEN)) u_rst_sequencer (
        .clk(clk), .rst(rst), .rst_pin_in(rst_pin_in), .int_req(int_req),
        .dbg_force_req(dbg_force_req), .mode_sel_in(mode_sel_in),
        .dbg_en_clr(dbg_en_clr), .sys_rst(sys_rst), .rst_pin_drive(rst_pin_drive),
        .reset_status(reset_status), .bkgd_mode(bkgd_mode),
        .dbg_pin_en(dbg_pin_en), .dbg_pullup_en(dbg_pullup_en)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic wait_release(output int cyc);
        cyc = 0;
        while (sys_rst && cyc < 2000) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic measure_pulse(output int len);
        len = 0;
        while (rst_pin_drive && len < 1000) begin
            len++;
            @(negedge clk);
        end
    endtask

    task automatic fire_int(input int idx);
        int_req[idx] = 1'b1;
        @(negedge clk);
        int_req[idx] = 1'b0;
    endtask

    task automatic t_por(input logic mode);
        int c;
        mode_sel_in = mode;
        rst = 1'b1;
        repeat (5) @(negedge clk);
        chk("R2", "sys_rst during por", sys_rst, 1);
        chk("R2", "no pin drive during por", rst_pin_drive, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R2", "no pin drive after por", rst_pin_drive, 0);
        wait_release(c);
        chk("R2", "por released", sys_rst, 0);
        chk("R3", "por status", reset_status, 1);
        chk("R6", "por mode", bkgd_mode, !mode);
        chk("R7", "dbg_pin_en after por", dbg_pin_en, 1);
        chk("R8", "pullup after por", dbg_pullup_en, 1);
    endtask

    task automatic t_internal;
        int len, c;
        mode_sel_in = 1'b0;
        fire_int(1);
        chk("R1", "sys_rst on int", sys_rst, 1);
        measure_pulse(len);
        chk("R1", "pulse length int", len, PLEN);
        wait_release(c);
        chk("R3", "status int1", reset_status, 32'h10);
        chk("R6", "mode not sampled on int", bkgd_mode, 0);
        mode_sel_in = 1'b1;
    endtask

    task automatic t_dbg_force(input logic mode);
        int len, c;
        mode_sel_in = mode;
        dbg_force_req = 1'b1;
        @(negedge clk);
        dbg_force_req = 1'b0;
        measure_pulse(len);
        chk("R1", "pulse length dbg", len, PLEN);
        wait_release(c);
        chk("R3", "status dbg", reset_status, 32'h4);
        chk("R6", "dbg force mode", bkgd_mode, !mode);
        mode_sel_in = 1'b1;
    endtask

    task automatic t_ext_hold;
        int len, c;
        ext_low = 1'b1;
        c = 0;
        while (!rst_pin_drive && c < 20) begin
            @(negedge clk);
            c++;
        end
        chk("R4", "pin reset started", sys_rst, 1);
        chk("R4", "pin cause", reset_status, 32'h2);
        measure_pulse(len);
        chk("R1", "pulse length pin", len, PLEN);
        repeat (50) @(negedge clk);
        chk("R10", "held while pin low", sys_rst, 1);
        ext_low = 1'b0;
        wait_release(c);
        chk("R10", "release after pin high", sys_rst, 0);
        chk("R10", "release delay bounded", (c <= 5), 1);
        chk("R6", "mode not sampled on pin", bkgd_mode, 0);
    endtask

    task automatic t_priority;
        int c, len;
        // both internal sources together: lower index wins
        int_req = 2'b11;
        @(negedge clk);
        int_req = '0;
        chk("R5", "int0 over int1", reset_status, 32'h8);
        measure_pulse(len);
        wait_release(c);
        // debug force with internal
        int_req = 2'b11;
        dbg_force_req = 1'b1;
        @(negedge clk);
        int_req = '0;
        dbg_force_req = 1'b0;
        chk("R5", "dbg over int", reset_status, 32'h4);
        measure_pulse(len);
        wait_release(c);
        // pin low edge and int1 in the same cycle: internal wins
        ext_low = 1'b1;
        @(negedge clk);
        @(negedge clk);
        int_req[1] = 1'b1;
        @(negedge clk);
        int_req[1] = 1'b0;
        ext_low = 1'b0;
        chk("R5", "int over pin", reset_status, 32'h10);
        measure_pulse(len);
        wait_release(c);
    endtask

    task automatic t_absorb;
        int c, len;
        fire_int(0);
        repeat (10) @(negedge clk);
        dbg_force_req = 1'b1;
        int_req = 2'b10;
        @(negedge clk);
        dbg_force_req = 1'b0;
        int_req = '0;
        chk("R9", "status kept mid pulse", reset_status, 32'h8);
        measure_pulse(len);
        chk("R9", "pulse not extended", len, PLEN - 11);
        wait_release(c);
        chk("R9", "status kept after release", reset_status, 32'h8);
        c = 0;
        repeat (100) begin
            @(negedge clk);
            if (sys_rst) c++;
        end
        chk("R9", "no queued reset", c, 0);
    endtask

    task automatic t_dbg_en;
        int c, len;
        dbg_en_clr = 1'b1;
        @(negedge clk);
        dbg_en_clr = 1'b0;
        chk("R7", "cleared by software", dbg_pin_en, 0);
        chk("R8", "pullup off", dbg_pullup_en, 0);
        fire_int(0);
        chk("R7", "set by reset", dbg_pin_en, 1);
        dbg_en_clr = 1'b1;
        @(negedge clk);
        dbg_en_clr = 1'b0;
        measure_pulse(len);
        wait_release(c);
        chk("R7", "clear ignored in reset", dbg_pin_en, 1);
        chk("R8", "pullup on", dbg_pullup_en, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_por(1'b1);
        t_internal();
        t_dbg_force(1'b0);
        t_dbg_force(1'b1);
        t_ext_hold();
        t_priority();
        t_absorb();
        t_dbg_en();
        t_dbg_force(1'b0);
        t_por(1'b0);
        chk("R3", "por clears other bits", reset_status, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule